// File: doc/BRIEF.md
# Real-Time Counter with Shared Prescaler

This block is an 8-bit real-time counter for a small controller core. Each count comes either from the core's instruction-cycle tick or from a chosen transition on an external pin. A single 8-stage power-of-two prescaler sits in front of either the counter or the watchdog, never both. The core loads a 6-bit mode word from its working register to pick the source, the edge, the owner of the prescaler and the ratio.

The watchdog counts ticks from an external base oscillator. It fires a one-cycle timeout after a fixed number of base ticks, multiplied by the prescale ratio when it owns the prescaler. A clear-watchdog strobe and entry into sleep both restart the watchdog. The timeout and power-down flags record what happened, and the core reads them after a reset. The pin is synchronized inside the block. The oscillator and the analog watchdog RC are not part of this block.

Top module: `rtc_psc_top`

## Requirements
- R1: After reset the counter reads 0x00, the timeout flag and the power-down flag both read 1, and no timeout pulse is present. The mode word is 0x3F, which selects the pin source, falling edge, prescaler on the watchdog and ratio code 7.
- R2: Mode word fields are as follows. Bits [2:0] are the ratio code PS. Bit 3 gives the prescaler owner: 0 for the counter, 1 for the watchdog. Bit 4 gives the pin edge: 0 for rising, 1 for falling. Bit 5 gives the source: 0 for the instruction tick, 1 for the pin. The word is loaded when mode_we_i is high.
- R3: When the prescaler belongs to the counter, the counter advances once per 2^(PS+1) source events, from 1:2 at PS=0 to 1:256 at PS=7.
- R4: When the prescaler belongs to the watchdog, the counter advances once per source event. It wraps from 0xFF to 0x00.
- R5: The pin passes through a two-flop synchronizer. A selected transition shows on the counter at the third rising clock edge after the pin changes. The opposite transition is not counted. While the pin source is selected, instruction ticks have no effect.
- R6: A counter write loads cnt_wdata_i and takes precedence over an increment in the same cycle. When the prescaler belongs to the counter, the write also clears the prescaler.
- R7: The watchdog times out after 2^WDT_BASE_W base ticks (16 by default) when it does not own the prescaler. It times out after 2^WDT_BASE_W * 2^PS base ticks when it does. The timeout is a one-cycle pulse, present in the cycle after the final tick is sampled.
- R8: A clear-watchdog strobe restarts the watchdog count, including the prescaler when the watchdog owns it. It sets the timeout flag to 1 and the power-down flag to 1.
- R9: A rising edge of sleep_i restarts the watchdog as in R8. It sets the timeout flag to 1 and the power-down flag to 0.
- R10: On a timeout outside sleep, the timeout flag becomes 0 and the power-down flag becomes 1. On a timeout during sleep, both flags become 0.
- R11: A mode write that changes the owner bit clears the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_we_i | input | 1 | Mode word load strobe |
| mode_wdata_i | input | 6 | Mode word from the working register |
| pin_i | input | 1 | External count pin, asynchronous |
| instr_tick_i | input | 1 | Instruction-cycle tick |
| wdt_tick_i | input | 1 | Watchdog base oscillator tick |
| cnt_we_i | input | 1 | Counter write strobe |
| cnt_wdata_i | input | 8 | Counter write data |
| wdt_clr_i | input | 1 | Clear-watchdog strobe |
| sleep_i | input | 1 | Core is in sleep (level) |
| cnt_o | output | 8 | Counter value |
| wdt_to_o | output | 1 | Watchdog timeout pulse |
| to_flag_o | output | 1 | Timeout flag |
| pd_flag_o | output | 1 | Power-down flag |

## Verification
The bench checks the ratio at PS=7 with both 255 and 256 ticks. A ratio off by one bit position would advance the counter at 255 ticks or stay still at 256. A write that fails to clear the prescaler, or a change of owner that fails to clear it, shows up as one extra increment after leftover ticks. The bench samples the counter at the second and third edges after a pin change, so a synchronizer one stage short or one stage long is caught. It also toggles the pin both ways in each edge mode. For the watchdog, the bench counts 15 ticks and then 16, restarts the count partway, and runs a timeout inside sleep. Flags that ignore the sleep state would leave the power-down flag at 1 in that case.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int RTC_PS_W   = 3;
  localparam int RTC_PSC_W  = 1 << RTC_PS_W;
  localparam int RTC_MODE_W = RTC_PS_W + 3;
  localparam logic [RTC_MODE_W-1:0] RTC_MODE_RST = '1;

  typedef struct packed {
    logic                src_pin;
    logic                edge_fall;
    logic                psc_wdt;
    logic [RTC_PS_W-1:0] ratio;
  } rtc_mode_t;
endpackage

// File: rtl/rtc_pin_sync.sv
module rtc_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[0] <= 1'b0;
        else         sync_q[0] <= pin_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[s] <= 1'b0;
        else         sync_q[s] <= sync_q[s-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;

  // R5
  rise_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
  // R5
  fall_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
  import rtc_pkg::*;
#(
  parameter int PS_W  = RTC_PS_W,
  parameter int PSC_W = RTC_PSC_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            to_wdt_i,
  input  logic [PS_W-1:0] ratio_i,
  input  logic            clr_i,
  input  logic            cnt_evt_i,
  input  logic            wdt_evt_i,
  output logic            cnt_fire_o,
  output logic            wdt_fire_o
);
  localparam logic [PSC_W:0] ONE = {{PSC_W{1'b0}}, 1'b1};

  logic [PSC_W-1:0] psc_q;
  logic [PS_W:0]    sh_cnt;
  logic [PSC_W:0]   mask_cnt, mask_wdt, psc_ext;
  logic             evt, hit;

  assign sh_cnt   = {1'b0, ratio_i} + {{PS_W{1'b0}}, 1'b1};
  assign mask_cnt = (ONE << sh_cnt) - ONE;   // counter side: 2^(PS+1)
  assign mask_wdt = (ONE << ratio_i) - ONE;  // watchdog side: 2^PS
  assign psc_ext  = {1'b0, psc_q};
  assign evt      = to_wdt_i ? wdt_evt_i : cnt_evt_i;

  always_comb begin
    if (to_wdt_i) hit = evt && ((psc_ext & mask_wdt) == mask_wdt);
    else          hit = evt && ((psc_ext & mask_cnt) == mask_cnt);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  psc_q <= '0;
    else if (clr_i) psc_q <= '0;
    else if (evt) psc_q <= psc_q + 1'b1;
  end

  assign cnt_fire_o = to_wdt_i ? cnt_evt_i : hit;
  assign wdt_fire_o = to_wdt_i ? hit : wdt_evt_i;

  // R3
  cnt_fire_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!to_wdt_i && cnt_fire_o) |-> cnt_evt_i);
  // R7
  wdt_fire_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_fire_o |-> wdt_evt_i);
endmodule

// File: rtl/rtc_watchdog.sv
module rtc_watchdog #(
  parameter int BASE_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  input  logic sleep_i,
  input  logic fire_i,
  output logic base_ovf_o,
  output logic restart_o,
  output logic to_pulse_o,
  output logic to_flag_o,
  output logic pd_flag_o
);
  logic [BASE_W-1:0] base_q;
  logic              sleep_q, sleep_rise;

  assign sleep_rise = sleep_i & ~sleep_q;
  assign restart_o  = clr_i | sleep_rise;
  assign base_ovf_o = tick_i & (&base_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      sleep_q <= 1'b0;
    end else begin
      sleep_q <= sleep_i;
      if (restart_o)   base_q <= '0;
      else if (tick_i) base_q <= base_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      to_pulse_o <= 1'b0;
      to_flag_o  <= 1'b1;
      pd_flag_o  <= 1'b1;
    end else begin
      to_pulse_o <= fire_i & ~restart_o;
      if (clr_i) begin
        to_flag_o <= 1'b1;
        pd_flag_o <= 1'b1;
      end else if (sleep_rise) begin
        to_flag_o <= 1'b1;
        pd_flag_o <= 1'b0;
      end else if (fire_i) begin
        to_flag_o <= 1'b0;
        pd_flag_o <= ~sleep_i;
      end
    end
  end

  // R8
  clr_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (to_flag_o && pd_flag_o));
  // R10
  to_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_pulse_o |-> (!to_flag_o && (pd_flag_o == !$past(sleep_i))));
  // R7
  to_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_pulse_o |=> !to_pulse_o);
endmodule

// File: rtl/rtc_psc_top.sv
module rtc_psc_top
  import rtc_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int WDT_BASE_W = 4,
  parameter int SYNC_STG   = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  mode_we_i,
  input  logic [RTC_MODE_W-1:0] mode_wdata_i,
  input  logic                  pin_i,
  input  logic                  instr_tick_i,
  input  logic                  wdt_tick_i,
  input  logic                  cnt_we_i,
  input  logic [CNT_W-1:0]      cnt_wdata_i,
  input  logic                  wdt_clr_i,
  input  logic                  sleep_i,
  output logic [CNT_W-1:0]      cnt_o,
  output logic                  wdt_to_o,
  output logic                  to_flag_o,
  output logic                  pd_flag_o
);
  rtc_mode_t        mode_q, mode_new;
  logic [CNT_W-1:0] cnt_q;
  logic             pin_rise, pin_fall, pin_evt, src_evt;
  logic             cnt_fire, wdt_fire, wdt_base_ovf, wdt_restart;
  logic             psc_clr;

  assign mode_new = rtc_mode_t'(mode_wdata_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= rtc_mode_t'(RTC_MODE_RST);
    else if (mode_we_i) mode_q <= mode_new;
  end

  rtc_pin_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  assign pin_evt = mode_q.edge_fall ? pin_fall : pin_rise;
  assign src_evt = mode_q.src_pin ? pin_evt : instr_tick_i;

  assign psc_clr = (cnt_we_i && !mode_q.psc_wdt)
                 || (wdt_restart && mode_q.psc_wdt)
                 || (mode_we_i && (mode_new.psc_wdt != mode_q.psc_wdt));

  rtc_prescaler u_psc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .to_wdt_i   (mode_q.psc_wdt),
    .ratio_i    (mode_q.ratio),
    .clr_i      (psc_clr),
    .cnt_evt_i  (src_evt),
    .wdt_evt_i  (wdt_base_ovf),
    .cnt_fire_o (cnt_fire),
    .wdt_fire_o (wdt_fire)
  );

  rtc_watchdog #(.BASE_W(WDT_BASE_W)) u_wdt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (wdt_tick_i),
    .clr_i      (wdt_clr_i),
    .sleep_i    (sleep_i),
    .fire_i     (wdt_fire),
    .base_ovf_o (wdt_base_ovf),
    .restart_o  (wdt_restart),
    .to_pulse_o (wdt_to_o),
    .to_flag_o  (to_flag_o),
    .pd_flag_o  (pd_flag_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (cnt_we_i) cnt_q <= cnt_wdata_i;
    else if (cnt_fire) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;

  // R6
  cnt_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i |=> (cnt_o == $past(cnt_wdata_i)));
  // R4
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_we_i |=> ((cnt_o == $past(cnt_o)) || (cnt_o == CNT_W'($past(cnt_o) + 1'b1))));
  // R5
  pin_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q.src_pin && !pin_rise && !pin_fall && !cnt_we_i) |=> $stable(cnt_o));
endmodule

// File: tb/rtc_psc_top_tb.sv
`timescale 1ns/1ps
module rtc_psc_top_tb;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       mode_we = 0, pin = 0, itick = 0, wtick = 0, cnt_we = 0, wclr = 0, sleep = 0;
  logic [5:0] mode_wd = '0;
  logic [7:0] cnt_wd = '0;
  logic [7:0] cnt;
  logic       wto, tof, pdf;
  int         total = 0, bad = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  rtc_psc_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_we_i(mode_we), .mode_wdata_i(mode_wd),
    .pin_i(pin), .instr_tick_i(itick), .wdt_tick_i(wtick), .cnt_we_i(cnt_we),
    .cnt_wdata_i(cnt_wd), .wdt_clr_i(wclr), .sleep_i(sleep),
    .cnt_o(cnt), .wdt_to_o(wto), .to_flag_o(tof), .pd_flag_o(pdf)
  );

  // {owner, ps, ticks, expected increments}
  localparam logic [20:0] VEC [7] = '{
    {1'b0, 3'd0, 9'd6,   8'd3},
    {1'b0, 3'd1, 9'd8,   8'd2},
    {1'b0, 3'd2, 9'd17,  8'd2},
    {1'b0, 3'd7, 9'd255, 8'd0},
    {1'b0, 3'd7, 9'd256, 8'd1},
    {1'b0, 3'd4, 9'd33,  8'd1},
    {1'b1, 3'd5, 9'd5,   8'd5}
  };

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_mode(logic [5:0] m);
    mode_wd = m; mode_we = 1; @(negedge clk); mode_we = 0;
  endtask

  task automatic wr_cnt(logic [7:0] v);
    cnt_wd = v; cnt_we = 1; @(negedge clk); cnt_we = 0;
  endtask

  task automatic iticks(int n);
    for (int i = 0; i < n; i++) begin itick = 1; @(negedge clk); end
    itick = 0;
  endtask

  task automatic clr_wdt();
    wclr = 1; @(negedge clk); wclr = 0;
  endtask

  task automatic wticks(int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      wtick = 1; @(negedge clk);
      if (wto) hits++;
    end
    wtick = 0;
  endtask

  initial begin
    int h;
    cyc(2);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 cnt", cnt, 8'h00);
    check("R1 to_flag", tof, 1);
    check("R1 pd_flag", pdf, 1);
    check("R1 timeout", wto, 0);
    // R1 reset mode: pin source, falling edge, no counter prescale
    pin = 1; cyc(4);
    check("R1 rise ignored", cnt, 8'h00);
    pin = 0; cyc(4);
    check("R1 fall counted", cnt, 8'h01);
    iticks(5); cyc(1);
    check("R1 tick ignored", cnt, 8'h01);

    // R2 R3 R4 ratio table
    foreach (VEC[k]) begin
      set_mode({1'b0, 1'b0, VEC[k][20], VEC[k][19:17]});
      wr_cnt(8'h10);
      iticks(int'(VEC[k][16:8])); cyc(1);
      check(VEC[k][20] ? "R4 per event" : "R3 ratio", cnt, 8'h10 + VEC[k][7:0]);
    end

    // R4 wrap
    set_mode(6'b001000);
    wr_cnt(8'hFE);
    iticks(3); cyc(1);
    check("R4 wrap", cnt, 8'h01);

    // R5 synchronizer latency and edge selection
    set_mode(6'b101000);
    wr_cnt(8'h40);
    pin = 1; cyc(2);
    check("R5 early", cnt, 8'h40);
    cyc(1);
    check("R5 rise 3rd edge", cnt, 8'h41);
    pin = 0; cyc(4);
    check("R5 fall ignored", cnt, 8'h41);
    set_mode(6'b111000);
    pin = 1; cyc(4);
    check("R5 rise ignored", cnt, 8'h41);
    pin = 0; cyc(4);
    check("R5 fall counted", cnt, 8'h42);
    iticks(3); cyc(1);
    check("R5 ticks ignored", cnt, 8'h42);

    // R6 write clears prescaler
    set_mode(6'b000010);
    wr_cnt(8'h20);
    iticks(5);
    wr_cnt(8'h30);
    iticks(7); cyc(1);
    check("R6 psc cleared", cnt, 8'h30);
    iticks(1); cyc(1);
    check("R6 after 8", cnt, 8'h31);
    // R6 write beats increment
    set_mode(6'b000000);
    wr_cnt(8'h50);
    iticks(1);
    itick = 1; wr_cnt(8'h60); itick = 0;
    check("R6 write wins", cnt, 8'h60);
    iticks(1); cyc(1);
    check("R6 clr on write", cnt, 8'h60);

    // R11 owner change clears prescaler
    set_mode(6'b000001);
    wr_cnt(8'h70);
    iticks(3);
    set_mode(6'b001001);
    set_mode(6'b000001);
    iticks(3); cyc(1);
    check("R11 cleared", cnt, 8'h70);
    iticks(1); cyc(1);
    check("R11 after 4", cnt, 8'h71);

    // R7 R8 R10 watchdog, no prescale
    set_mode(6'b000000);
    clr_wdt();
    check("R8 flags to", tof, 1);
    wticks(15, h); check("R7 15 ticks", h, 0);
    wticks(1, h);  check("R7 16th tick", h, 1);
    check("R10 to awake", tof, 0);
    check("R10 pd awake", pdf, 1);
    clr_wdt();
    check("R8 to", tof, 1);
    check("R8 pd", pdf, 1);
    wticks(10, h);
    clr_wdt();
    wticks(15, h); check("R8 restart", h, 0);
    wticks(1, h);  check("R8 restart end", h, 1);

    // R7 watchdog with prescale 1:2
    set_mode(6'b001001);
    clr_wdt();
    wticks(31, h); check("R7 psc 31", h, 0);
    wticks(1, h);  check("R7 psc 32", h, 1);

    // R9 R10 sleep
    set_mode(6'b000000);
    clr_wdt();
    sleep = 1; cyc(1);
    check("R9 to", tof, 1);
    check("R9 pd", pdf, 0);
    wticks(15, h); check("R9 restart", h, 0);
    wticks(1, h);  check("R10 sleep timeout", h, 1);
    check("R10 to sleep", tof, 0);
    check("R10 pd sleep", pdf, 0);
    sleep = 0;
    clr_wdt();
    check("R8 wake clr", pdf, 1);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired act=0 exp=1");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule